// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one channel of an event timer. It watches a free-running main counter that is supplied from outside and compares it with a programmable comparator. When the two meet, it produces a one-cycle event pulse and sets a pending flag. The channel runs either once (one-shot) or periodically. In periodic mode a hidden period register moves the comparator forward after every match. A narrow mode restricts the comparator, the period and the comparison to the low half of the counter width.

Software programs the channel through a simple write port with three targets: a configuration word, the low comparator word and the high comparator word. It reads the configuration, comparator and period back as half-width words through a select input. The block does not route interrupts or decode a bus. A global enable input gates all event generation.

Top module: `tmr_chan`

## Requirements
- R1: After reset the configuration reads 0, both comparator words read all ones, both period words read 0, and `event_o` and `pend_o` are low.
- R2: Write select 1 writes the low comparator word and select 2 writes the high word. In one-shot mode (configuration bit 1 clear) both writes load the comparator directly, and the values read back on read selects 1 and 2. Read select 0 returns the configuration word: bit 0 channel enable, bit 1 periodic, bit 2 load-comparator (SETVAL), bit 3 narrow.
- R3: In periodic mode with SETVAL clear, a comparator write changes only the hidden period (read selects 3 and 4) and leaves the comparator readback unchanged.
- R4: In periodic mode with SETVAL set, a low-word write loads both the comparator and the period, and a high-word write loads the comparator. Any comparator write clears SETVAL.
- R5: A value written into the period has the period's top bit forced to 0. In wide mode that is the top bit of the high word; in narrow mode it is bit HALF_W-1 of the low word.
- R6: While the channel is armed and the global enable is high, `event_o` pulses for exactly one cycle on the clock after the edge at which the counter first equals the comparator. `pend_o` is set at the same time.
- R7: After a periodic match, the comparator advances by the period. It keeps advancing by one period per cycle until it lies ahead of the counter by signed wrap-around comparison.
- R8: Setting the narrow bit clears the upper comparator and period halves. In narrow mode, high-word writes do not change the comparator or the period, and a match compares only the low counter half.
- R9: In narrow one-shot mode, if the low counter half reaches all ones before it reaches the comparator, an extra event fires at that wrap point, and the comparator match still fires afterwards.
- R10: A 0-to-1 write of the enable bit arms the channel only while the global enable is high. A rising global enable arms a channel whose enable bit is set. A 1-to-0 write of the enable bit, or a low global enable, disarms the channel and clears `pend_o`, and a disarmed channel produces no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global enable for all event generation |
| count_i | input | CNT_W | Main counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 configuration, 1 comparator low, 2 comparator high |
| wr_data_i | input | CNT_W/2 | Write data |
| rd_sel_i | input | 3 | Read select: 0 configuration, 1/2 comparator low/high, 3/4 period low/high |
| rd_data_o | output | CNT_W/2 | Read data, combinational |
| event_o | output | 1 | One-cycle match or wrap event |
| pend_o | output | 1 | Sticky pending flag, cleared on disarm |

## Verification
The bench sweeps the counter one step at a time across each comparator point and checks the event output at every step against a value computed arithmetically in the bench.

The corner cases it targets, and how a faulty design would show up:
- **Periodic spacing.** A periodic run must give events spaced exactly one period apart. A design that fails to advance the comparator would fire only once.
- **Counter jump.** When the counter jumps ahead after a match, the comparator must catch up. A design that advances only once would be left behind the counter and go silent.
- **Narrow one-shot wrap.** This run must give two events, one at the wrap point and one at the match. A design missing the wrap rule gives one event; a design comparing all bits gives none.
- **Period masking.** Period masking, truncation on entry to narrow mode, and SETVAL self-clearing are read back directly, so a wrong mask or a sticky SETVAL shows up as a readback mismatch.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    localparam int CFG_BITS = 4;

    // bit 3 narrow, bit 2 load-comparator, bit 1 periodic, bit 0 enable
    typedef struct packed {
        logic narrow;
        logic setval;
        logic periodic;
        logic en;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        WSEL_CFG    = 2'd0,
        WSEL_CMP_LO = 2'd1,
        WSEL_CMP_HI = 2'd2,
        WSEL_NONE   = 2'd3
    } wsel_e;

    typedef enum logic [2:0] {
        RSEL_CFG    = 3'd0,
        RSEL_CMP_LO = 3'd1,
        RSEL_CMP_HI = 3'd2,
        RSEL_PER_LO = 3'd3,
        RSEL_PER_HI = 3'd4
    } rsel_e;

endpackage

// File: rtl/tmr_chan_cmp.sv
// Comparison arithmetic between comparator and counter, wide or narrow.
module tmr_chan_cmp #(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             narrow_i,
    output logic             hit_o,
    output logic             ahead_o,
    output logic             wrap_first_o,
    output logic             at_top_o
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  diff_w;
    logic [HALF_W-1:0] diff_n;
    logic [HALF_W-1:0] diff_clamp;
    logic [HALF_W-1:0] to_wrap;
    logic              ahead_w;
    logic              ahead_n;

    always_comb begin
        diff_w     = cmp_i - count_i;
        diff_n     = cmp_i[HALF_W-1:0] - count_i[HALF_W-1:0];
        ahead_w    = !diff_w[CNT_W-1] && (diff_w != '0);
        ahead_n    = !diff_n[HALF_W-1] && (diff_n != '0);
        ahead_o    = narrow_i ? ahead_n : ahead_w;
        hit_o      = narrow_i ? (cmp_i[HALF_W-1:0] == count_i[HALF_W-1:0])
                              : (cmp_i == count_i);
        // distance to match, at least one tick
        diff_clamp = ahead_n ? diff_n : HALF_W'(1);
        to_wrap    = ~count_i[HALF_W-1:0];
        wrap_first_o = to_wrap < diff_clamp;
        at_top_o   = &count_i[HALF_W-1:0];
    end
endmodule

// File: rtl/tmr_chan_rdmux.sv
// Read-back selection of half-width words.
module tmr_chan_rdmux
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  chan_cfg_t               cfg_i,
    input  logic [CNT_W-1:0]        cmp_i,
    input  logic [CNT_W-1:0]        per_i,
    input  logic [2:0]              sel_i,
    output logic [CNT_W/2-1:0]      data_o
);
    localparam int HALF_W = CNT_W / 2;

    always_comb begin
        case (rsel_e'(sel_i))
            RSEL_CFG:    data_o = HALF_W'(cfg_i);
            RSEL_CMP_LO: data_o = cmp_i[HALF_W-1:0];
            RSEL_CMP_HI: data_o = cmp_i[CNT_W-1:HALF_W];
            RSEL_PER_LO: data_o = per_i[HALF_W-1:0];
            RSEL_PER_HI: data_o = per_i[CNT_W-1:HALF_W];
            default:     data_o = '0;
        endcase
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                glb_en_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [CNT_W/2-1:0]  wr_data_i,
    input  logic [2:0]          rd_sel_i,
    output logic [CNT_W/2-1:0]  rd_data_o,
    output logic                event_o,
    output logic                pend_o
);
    localparam int HALF_W = CNT_W / 2;

    typedef struct packed {
        chan_cfg_t        cfg;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] per;
        logic             armed;
        logic             arm_chk;
        logic             wrap_pend;
        logic             catchup;
        logic             hit_prev;
        logic             glb_prev;
        logic             evt;
        logic             pend;
    } state_t;

    state_t s_d, s_q;

    logic hit, ahead, wrap_first, at_top;
    logic live, wrap_evt, cmp_evt, load_cmp;
    logic [CNT_W-1:0] adv;
    chan_cfg_t new_cfg;

    tmr_chan_cmp #(.CNT_W(CNT_W)) cmp_i (
        .cmp_i        (s_q.cmp),
        .count_i      (count_i),
        .narrow_i     (s_q.cfg.narrow),
        .hit_o        (hit),
        .ahead_o      (ahead),
        .wrap_first_o (wrap_first),
        .at_top_o     (at_top)
    );

    tmr_chan_rdmux #(.CNT_W(CNT_W)) rdmux_i (
        .cfg_i  (s_q.cfg),
        .cmp_i  (s_q.cmp),
        .per_i  (s_q.per),
        .sel_i  (rd_sel_i),
        .data_o (rd_data_o)
    );

    always_comb begin
        s_d          = s_q;
        s_d.evt      = 1'b0;
        s_d.arm_chk  = 1'b0;
        s_d.hit_prev = hit;
        s_d.glb_prev = glb_en_i;
        new_cfg      = chan_cfg_t'(wr_data_i[CFG_BITS-1:0]);
        load_cmp     = !s_q.cfg.periodic || s_q.cfg.setval;
        adv          = s_q.cfg.narrow
                     ? {{HALF_W{1'b0}}, s_q.cmp[HALF_W-1:0] + s_q.per[HALF_W-1:0]}
                     : s_q.cmp + s_q.per;

        live = s_q.armed && glb_en_i;

        // wrap decision is taken one cycle after arming, on the updated comparator
        if (s_q.arm_chk) begin
            s_d.wrap_pend = s_q.cfg.narrow && !s_q.cfg.periodic && wrap_first;
        end

        wrap_evt = live && s_q.wrap_pend && at_top
                   && s_q.cfg.narrow && !s_q.cfg.periodic;
        cmp_evt  = live && hit && !s_q.hit_prev;

        if (wrap_evt) begin
            s_d.wrap_pend = 1'b0;
        end
        if (wrap_evt || cmp_evt) begin
            s_d.evt  = 1'b1;
            s_d.pend = 1'b1;
        end

        // periodic self-advance and catch-up
        if (live && s_q.cfg.periodic && (s_q.per != '0) && (cmp_evt || s_q.catchup)) begin
            if (!ahead) begin
                s_d.cmp     = adv;
                s_d.catchup = 1'b1;
            end else begin
                s_d.catchup = 1'b0;
            end
        end else begin
            s_d.catchup = 1'b0;
        end

        // global enable edges
        if (!glb_en_i) begin
            s_d.armed     = 1'b0;
            s_d.pend      = 1'b0;
            s_d.wrap_pend = 1'b0;
            s_d.catchup   = 1'b0;
        end else if (!s_q.glb_prev && s_q.cfg.en) begin
            s_d.armed   = 1'b1;
            s_d.arm_chk = 1'b1;
        end

        // register writes
        if (wr_en_i) begin
            case (wsel_e'(wr_sel_i))
                WSEL_CFG: begin
                    s_d.cfg = new_cfg;
                    if (new_cfg.narrow) begin
                        s_d.cmp[CNT_W-1:HALF_W]   = '0;
                        s_d.per[CNT_W-1:HALF_W-1] = '0;
                    end
                    if (new_cfg.en && !s_q.cfg.en && glb_en_i) begin
                        s_d.armed   = 1'b1;
                        s_d.arm_chk = 1'b1;
                        s_d.catchup = 1'b0;
                    end else if (!new_cfg.en && s_q.cfg.en) begin
                        s_d.armed     = 1'b0;
                        s_d.pend      = 1'b0;
                        s_d.evt       = 1'b0;
                        s_d.wrap_pend = 1'b0;
                        s_d.catchup   = 1'b0;
                    end
                end
                WSEL_CMP_LO: begin
                    if (load_cmp) begin
                        s_d.cmp[HALF_W-1:0] = wr_data_i;
                    end
                    if (s_q.cfg.periodic) begin
                        s_d.per[HALF_W-1:0] = s_q.cfg.narrow
                                            ? {1'b0, wr_data_i[HALF_W-2:0]}
                                            : wr_data_i;
                    end
                    s_d.cfg.setval = 1'b0;
                    s_d.catchup    = 1'b0;
                    s_d.arm_chk    = s_q.armed;
                end
                WSEL_CMP_HI: begin
                    if (!s_q.cfg.narrow) begin
                        if (load_cmp) begin
                            s_d.cmp[CNT_W-1:HALF_W] = wr_data_i;
                        end else begin
                            s_d.per[CNT_W-1:HALF_W] = {1'b0, wr_data_i[HALF_W-2:0]};
                        end
                    end
                    s_d.cfg.setval = 1'b0;
                    s_d.catchup    = 1'b0;
                    s_d.arm_chk    = s_q.armed;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q     <= '0;
            s_q.cmp <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign event_o = s_q.evt;
    assign pend_o  = s_q.pend;

    // ---------------- assertions ----------------
    assert_narrow_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cfg.narrow |-> (s_q.cmp[CNT_W-1:HALF_W] == '0) && (s_q.per[CNT_W-1:HALF_W] == '0));

    assert_period_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cfg.narrow ? !s_q.per[HALF_W-1] : !s_q.per[CNT_W-1]);

    assert_setval_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_sel_i == WSEL_CMP_LO || wr_sel_i == WSEL_CMP_HI)) |=> !s_q.cfg.setval);

    assert_event_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_o |-> pend_o);

    assert_disarm_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == WSEL_CFG && !wr_data_i[0] && s_q.cfg.en) |=> (!pend_o && !event_o));

    assert_glb_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !glb_en_i |=> (!s_q.armed && !pend_o));
endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb_top;
    localparam int CNT_W  = 64;
    localparam int HALF_W = CNT_W / 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              glb_en;
    logic [CNT_W-1:0]  count;
    logic              wr_en;
    logic [1:0]        wr_sel;
    logic [HALF_W-1:0] wr_data;
    logic [2:0]        rd_sel;
    logic [HALF_W-1:0] rd_data;
    logic              event_w;
    logic              pend_w;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tmr_chan #(.CNT_W(CNT_W)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .glb_en_i  (glb_en),
        .count_i   (count),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .event_o   (event_w),
        .pend_o    (pend_w)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
        rd_sel = sel;
        #1;
        chk(tag, {32'd0, rd_data}, {32'd0, exp});
    endtask

    // apply one counter value, return event seen after that edge
    task automatic step(input logic [63:0] v, output logic ev);
        count = v;
        @(negedge clk);
        ev = event_w;
    endtask

    initial begin
        logic ev;
        int   nev;
        rst_n = 1'b0; glb_en = 1'b0; count = '0;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, 32'h0, "R1 cfg");
        rd(3'd1, 32'hFFFF_FFFF, "R1 cmp lo");
        rd(3'd2, 32'hFFFF_FFFF, "R1 cmp hi");
        rd(3'd3, 32'h0, "R1 per lo");
        rd(3'd4, 32'h0, "R1 per hi");
        chk("R1 event", {63'd0, event_w}, 64'd0);
        chk("R1 pend", {63'd0, pend_w}, 64'd0);

        // R2 / R6 one-shot wide
        glb_en = 1'b1;
        wr(2'd1, 32'd100);
        wr(2'd2, 32'd0);
        rd(3'd1, 32'd100, "R2 cmp lo");
        rd(3'd2, 32'd0, "R2 cmp hi");
        count = 64'd90;
        wr(2'd0, 32'h1);
        rd(3'd0, 32'h1, "R2 cfg");
        nev = 0;
        for (int v = 90; v <= 110; v++) begin
            step(64'(v), ev);
            chk("R6 one-shot event", {63'd0, ev}, {63'd0, (v == 100)});
            nev += int'(ev);
        end
        chk("R6 one pulse", 64'(nev), 64'd1);
        chk("R6 pend set", {63'd0, pend_w}, 64'd1);
        wr(2'd0, 32'h0);
        chk("R10 pend cleared", {63'd0, pend_w}, 64'd0);

        // R4 / R3 / R7 periodic
        wr(2'd0, 32'h6);
        rd(3'd0, 32'h6, "R4 cfg setval");
        wr(2'd2, 32'd0);
        rd(3'd0, 32'h2, "R4 setval self-clear");
        wr(2'd0, 32'h6);
        wr(2'd1, 32'd200);
        rd(3'd1, 32'd200, "R4 cmp loaded");
        rd(3'd3, 32'd200, "R4 per loaded");
        rd(3'd2, 32'd0, "R4 cmp hi");
        count = 64'd150;
        wr(2'd0, 32'h3);
        nev = 0;
        for (int v = 150; v <= 1001; v++) begin
            step(64'(v), ev);
            chk("R7 periodic event", {63'd0, ev}, {63'd0, (v % 200 == 0)});
            nev += int'(ev);
        end
        chk("R7 periodic count", 64'(nev), 64'd5);
        wr(2'd1, 32'd50);
        rd(3'd3, 32'd50, "R3 period only");
        rd(3'd1, 32'd1200, "R3 cmp unchanged");
        step(64'd1200, ev);
        chk("R7 match before jump", {63'd0, ev}, 64'd1);
        for (int i = 0; i < 5; i++) begin
            step(64'd1380, ev);
            chk("R7 no event in catch-up", {63'd0, ev}, 64'd0);
        end
        rd(3'd1, 32'd1400, "R7 catch-up result");
        wr(2'd0, 32'h2);
        chk("R10 pend cleared periodic", {63'd0, pend_w}, 64'd0);

        // R10 global enable gating
        glb_en = 1'b0;
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h300);
        count = 64'h2F0;
        wr(2'd0, 32'h1);
        nev = 0;
        for (int v = 'h2F0; v <= 'h310; v++) begin
            step(64'(v), ev);
            nev += int'(ev);
        end
        chk("R10 no event while global off", 64'(nev), 64'd0);
        count = 64'h2F0;
        glb_en = 1'b1;
        step(64'h2F0, ev);
        nev = 0;
        for (int v = 'h2F1; v <= 'h310; v++) begin
            step(64'(v), ev);
            chk("R10 armed by global rise", {63'd0, ev}, {63'd0, (v == 'h300)});
            nev += int'(ev);
        end
        chk("R10 single event", 64'(nev), 64'd1);
        wr(2'd0, 32'h0);
        chk("R10 disarm clears pend", {63'd0, pend_w}, 64'd0);
        nev = 0;
        for (int v = 'h2F0; v <= 'h310; v++) begin
            step(64'(v), ev);
            nev += int'(ev);
        end
        chk("R10 disarmed silent", 64'(nev), 64'd0);

        // R5 / R8 masking and truncation
        wr(2'd0, 32'h2);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(3'd3, 32'hFFFF_FFFF, "R5 wide per lo");
        rd(3'd1, 32'h300, "R3 cmp kept");
        wr(2'd2, 32'hFFFF_FFFF);
        rd(3'd4, 32'h7FFF_FFFF, "R5 wide per hi mask");
        wr(2'd0, 32'hA);
        rd(3'd3, 32'h7FFF_FFFF, "R8 per lo truncated");
        rd(3'd4, 32'h0, "R8 per hi cleared");
        rd(3'd2, 32'h0, "R8 cmp hi cleared");
        wr(2'd1, 32'hFFFF_FFFF);
        rd(3'd3, 32'h7FFF_FFFF, "R5 narrow per mask");
        wr(2'd2, 32'h1234);
        rd(3'd4, 32'h0, "R8 per hi ignored");
        wr(2'd0, 32'h8);
        wr(2'd2, 32'h55);
        rd(3'd2, 32'h0, "R8 cmp hi ignored");

        // R9 narrow one-shot wrap
        wr(2'd1, 32'h10);
        rd(3'd1, 32'h10, "R9 cmp lo");
        count = 64'h5_FFFF_FFF0;
        wr(2'd0, 32'h9);
        nev = 0;
        for (logic [63:0] v = 64'h5_FFFF_FFF0; v <= 64'h6_0000_0014; v++) begin
            step(v, ev);
            chk("R9 wrap/match event", {63'd0, ev},
                {63'd0, (v[31:0] == 32'hFFFF_FFFF) || (v[31:0] == 32'h10)});
            nev += int'(ev);
        end
        chk("R9 two events", 64'(nev), 64'd2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule